// File: doc/BRIEF.md
# RAM ECC Event Monitor

This block collects ECC diagnostic events from a set of RAM ECC controllers and reports them to software over a simple word-wide register interface. Each controller feeds one monitor slot with an event kind plus the address, data word and check code of the access that failed. The ECC encode and decode logic sits in the controllers and is not part of this block.

Each slot has its own configuration register, three sticky error flags, and a captured error context: failing address, failing data (low and high halves) and failing check code. The context is captured only when the slot's latching enable is set and the error happened on a read. One shared register holds a master interrupt enable and three class-wide enables. A single interrupt line is raised from the flags through these enables. The number of slots, the bus address width and the RAM word width (32 or 64 bits) are parameters.

Top module: `ecc_event_monitor`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The global enable register at offset 0x00 stores bits 3:0 (bit 0 master, bit 1 single-error class, bit 2 double-error-on-read class, bit 3 double-error-on-partial-write class); all other bits read zero.
- R3: Slot x (1..NUM_MON) has its configuration register at 0x20*x. Bits 5:2 are stored (bit 2 single-error interrupt, bit 3 read double-error interrupt, bit 4 partial-write double-error interrupt, bit 5 context latching). Bits 1:0 and 31:6 read zero.
- R4: An event of kind 1 (corrected single error), kind 2 (double error on read) or kind 3 (double error on partial write) sets bit 0, bit 1 or bit 2 respectively of the slot status register at 0x20*x+4. Kind 0 means no event. Flags stay set until software clears them.
- R5: A status write clears each flag whose written bit is 0 and leaves a flag alone where the bit is 1. A flag that hardware sets in the same cycle as a clearing write ends up set.
- R6: With latching enabled, a kind 1 or kind 2 event stores its address at 0x20*x+8, data low at +0xC, data high at +0x10 and code at +0x14. A later such event overwrites them. Kind 3 events, and any event while latching is disabled, leave the context unchanged.
- R7: When built for a 32-bit RAM (WIDE_DATA=0), the data-low register holds the whole failing word and the data-high register reads zero.
- R8: `irq` is high exactly when the master enable is set and some slot has a flag set whose global class enable or slot enable is set.
- R9: Only accesses with `reg_size` = 2'b10 (word) take effect. A byte (2'b00) or half-word (2'b01) write changes nothing, and such a read returns zero.
- R10: Events arriving in the same cycle on different slots update only their own flags and context.
- R11: Reads of unmapped offsets, or of slots above NUM_MON, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access valid this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_size | input | 2 | Access size: 00 byte, 01 half-word, 10 word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the access |
| evt_kind | input | 2*NUM_MON | Event kind per slot (0 none, 1 single, 2 double read, 3 double partial write) |
| evt_addr | input | 32*NUM_MON | Failing address per slot |
| evt_data | input | DATA_W*NUM_MON | Failing data word per slot (DATA_W = 64 or 32) |
| evt_code | input | 32*NUM_MON | Failing check code per slot |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two instances. The first uses the default five slots with 64-bit data, so it reaches every slot offset, the top unmapped slot index, the full data-high path and events firing on three slots at once. The second has two slots and WIDE_DATA=0. It covers the narrow variant, where the data-high register is not built and must read zero while data-low carries the whole word.

// File: rtl/ecc_mon_pkg.sv
package ecc_mon_pkg;
   typedef enum logic [1:0] {
      EV_NONE   = 2'd0,
      EV_SINGLE = 2'd1,
      EV_DBL_RD = 2'd2,
      EV_DBL_PW = 2'd3
   } ev_kind_t;

   localparam logic [4:0] OFF_CFG = 5'h00;
   localparam logic [4:0] OFF_STS = 5'h04;
   localparam logic [4:0] OFF_FAR = 5'h08;
   localparam logic [4:0] OFF_FDL = 5'h0C;
   localparam logic [4:0] OFF_FDH = 5'h10;
   localparam logic [4:0] OFF_FEC = 5'h14;

   localparam logic [1:0] SZ_WORD = 2'b10;
   localparam int SLOT_SHIFT = 5;
endpackage

// File: rtl/ecc_mon_slot.sv
module ecc_mon_slot
   import ecc_mon_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_wdata,
   input  logic              sts_we,
   input  logic [2:0]        sts_wdata,
   input  ev_kind_t          ev_kind,
   input  logic [31:0]       ev_addr,
   input  logic [DATA_W-1:0] ev_data,
   input  logic [31:0]       ev_code,
   input  logic [2:0]        class_en,
   output logic [3:0]        cfg,
   output logic [2:0]        flags,
   output logic [31:0]       far,
   output logic [31:0]       fdl,
   output logic [31:0]       fdh,
   output logic [31:0]       fec,
   output logic              irq_req
);
   logic [2:0] set_vec;
   logic       latch;

   always_comb begin
      set_vec = 3'b000;
      case (ev_kind)
         EV_SINGLE: set_vec = 3'b001;
         EV_DBL_RD: set_vec = 3'b010;
         EV_DBL_PW: set_vec = 3'b100;
         default:   set_vec = 3'b000;
      endcase
   end

   assign latch = cfg[3] && (ev_kind == EV_SINGLE || ev_kind == EV_DBL_RD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg   <= '0;
         flags <= '0;
         far   <= '0;
         fdl   <= '0;
         fec   <= '0;
      end else begin
         if (cfg_we) cfg <= cfg_wdata;
         flags <= (sts_we ? (flags & sts_wdata) : flags) | set_vec;
         if (latch) begin
            far <= ev_addr;
            fdl <= ev_data[31:0];
            fec <= ev_code;
         end
      end
   end

   generate
      if (DATA_W > 32) begin : g_wide
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     fdh <= '0;
            else if (latch) fdh <= ev_data[DATA_W-1:32];
         end
      end else begin : g_narrow
         assign fdh = '0;
      end
   endgenerate

   assign irq_req = |(flags & (class_en | cfg[2:0]));
endmodule

// File: rtl/ecc_mon_regif.sv
module ecc_mon_regif
   import ecc_mon_pkg::*;
#(
   parameter int NUM_MON = 5,
   parameter int ADDR_W  = 8
) (
   input  logic                       reg_sel,
   input  logic                       reg_wr,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [1:0]                 reg_size,
   input  logic [3:0]                 glob_en,
   input  logic [NUM_MON-1:0][3:0]    cfg_all,
   input  logic [NUM_MON-1:0][2:0]    flags_all,
   input  logic [NUM_MON-1:0][31:0]   far_all,
   input  logic [NUM_MON-1:0][31:0]   fdl_all,
   input  logic [NUM_MON-1:0][31:0]   fdh_all,
   input  logic [NUM_MON-1:0][31:0]   fec_all,
   output logic                       glob_we,
   output logic [NUM_MON-1:0]         cfg_we,
   output logic [NUM_MON-1:0]         sts_we,
   output logic [31:0]                reg_rdata
);
   localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

   logic              word_ok;
   logic              wr_ok;
   logic              rd_ok;
   logic [SLOT_W-1:0] slot;
   logic [4:0]        off;

   assign word_ok = reg_sel && (reg_size == SZ_WORD);
   assign wr_ok   = word_ok && reg_wr;
   assign rd_ok   = word_ok && !reg_wr;
   assign slot    = reg_addr[ADDR_W-1:SLOT_SHIFT];
   assign off     = reg_addr[SLOT_SHIFT-1:0];

   assign glob_we = wr_ok && (slot == '0) && (off == OFF_CFG);

   generate
      for (genvar k = 0; k < NUM_MON; k++) begin : g_dec
         assign cfg_we[k] = wr_ok && (slot == SLOT_W'(k + 1)) && (off == OFF_CFG);
         assign sts_we[k] = wr_ok && (slot == SLOT_W'(k + 1)) && (off == OFF_STS);
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      if (rd_ok) begin
         if (slot == '0 && off == OFF_CFG) reg_rdata = {28'b0, glob_en};
         for (int k = 0; k < NUM_MON; k++) begin
            if (slot == SLOT_W'(k + 1)) begin
               case (off)
                  OFF_CFG: reg_rdata = {26'b0, cfg_all[k], 2'b00};
                  OFF_STS: reg_rdata = {29'b0, flags_all[k]};
                  OFF_FAR: reg_rdata = far_all[k];
                  OFF_FDL: reg_rdata = fdl_all[k];
                  OFF_FDH: reg_rdata = fdh_all[k];
                  OFF_FEC: reg_rdata = fec_all[k];
                  default: reg_rdata = '0;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/ecc_event_monitor.sv
module ecc_event_monitor
   import ecc_mon_pkg::*;
#(
   parameter int NUM_MON   = 5,
   parameter int ADDR_W    = 8,
   parameter int WIDE_DATA = 1,
   localparam int DATA_W   = (WIDE_DATA != 0) ? 64 : 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_sel,
   input  logic                      reg_wr,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [1:0]                reg_size,
   input  logic [31:0]               reg_wdata,
   output logic [31:0]               reg_rdata,
   input  logic [2*NUM_MON-1:0]      evt_kind,
   input  logic [32*NUM_MON-1:0]     evt_addr,
   input  logic [DATA_W*NUM_MON-1:0] evt_data,
   input  logic [32*NUM_MON-1:0]     evt_code,
   output logic                      irq
);
   generate
      if (NUM_MON < 1 || (NUM_MON + 1) > (1 << (ADDR_W - SLOT_SHIFT))) begin : g_bad_cfg
         $error("ecc_event_monitor: NUM_MON does not fit the address width");
      end
      if (WIDE_DATA != 0 && WIDE_DATA != 1) begin : g_bad_wide
         $error("ecc_event_monitor: WIDE_DATA must be 0 or 1");
      end
   endgenerate

   logic [3:0]                glob_en;
   logic                      glob_we;
   logic [NUM_MON-1:0]        cfg_we;
   logic [NUM_MON-1:0]        sts_we;
   logic [NUM_MON-1:0][3:0]   cfg_all;
   logic [NUM_MON-1:0][2:0]   flags_all;
   logic [NUM_MON-1:0][31:0]  far_all;
   logic [NUM_MON-1:0][31:0]  fdl_all;
   logic [NUM_MON-1:0][31:0]  fdh_all;
   logic [NUM_MON-1:0][31:0]  fec_all;
   logic [NUM_MON-1:0]        irq_req;
   logic                      unused_wdata;

   assign unused_wdata = ^reg_wdata[31:6];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       glob_en <= '0;
      else if (glob_we) glob_en <= reg_wdata[3:0];
   end

   ecc_mon_regif #(.NUM_MON(NUM_MON), .ADDR_W(ADDR_W)) u_regif (
      .reg_sel   (reg_sel),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_size  (reg_size),
      .glob_en   (glob_en),
      .cfg_all   (cfg_all),
      .flags_all (flags_all),
      .far_all   (far_all),
      .fdl_all   (fdl_all),
      .fdh_all   (fdh_all),
      .fec_all   (fec_all),
      .glob_we   (glob_we),
      .cfg_we    (cfg_we),
      .sts_we    (sts_we),
      .reg_rdata (reg_rdata)
   );

   generate
      for (genvar k = 0; k < NUM_MON; k++) begin : g_slot
         ecc_mon_slot #(.DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we[k]),
            .cfg_wdata (reg_wdata[5:2]),
            .sts_we    (sts_we[k]),
            .sts_wdata (reg_wdata[2:0]),
            .ev_kind   (ev_kind_t'(evt_kind[2*k +: 2])),
            .ev_addr   (evt_addr[32*k +: 32]),
            .ev_data   (evt_data[DATA_W*k +: DATA_W]),
            .ev_code   (evt_code[32*k +: 32]),
            .class_en  (glob_en[3:1]),
            .cfg       (cfg_all[k]),
            .flags     (flags_all[k]),
            .far       (far_all[k]),
            .fdl       (fdl_all[k]),
            .fdh       (fdh_all[k]),
            .fec       (fec_all[k]),
            .irq_req   (irq_req[k])
         );
      end
   endgenerate

   assign irq = glob_en[0] && (|irq_req);
endmodule

// File: rtl/ecc_mon_chk.sv
module ecc_mon_chk #(
   parameter int NUM_MON = 5
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      reg_sel,
   input logic [1:0]                reg_size,
   input logic [31:0]               reg_rdata,
   input logic                      irq,
   input logic [3:0]                glob_en,
   input logic [2*NUM_MON-1:0]      evt_kind,
   input logic [NUM_MON-1:0]        sts_we,
   input logic [NUM_MON-1:0][3:0]   cfg_all,
   input logic [NUM_MON-1:0][2:0]   flags_all,
   input logic [NUM_MON-1:0][31:0]  far_all
);
   assert_irq_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en[0] |-> !irq);

   assert_bad_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel && reg_size != 2'b10) |-> (reg_rdata == 32'h0));

   generate
      for (genvar k = 0; k < NUM_MON; k++) begin : g_k
         assert_single_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_kind[2*k +: 2] == 2'd1) |=> flags_all[k][0]);

         assert_pw_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_kind[2*k +: 2] == 2'd3) |=> flags_all[k][2]);

         assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !sts_we[k] |=> ((flags_all[k] & $past(flags_all[k])) == $past(flags_all[k])));

         assert_ctx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_all[k][3] && (evt_kind[2*k +: 2] == 2'd1 || evt_kind[2*k +: 2] == 2'd2))
            |=> $stable(far_all[k]));
      end
   endgenerate
endmodule

bind ecc_event_monitor ecc_mon_chk #(.NUM_MON(NUM_MON)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_sel   (reg_sel),
   .reg_size  (reg_size),
   .reg_rdata (reg_rdata),
   .irq       (irq),
   .glob_en   (glob_en),
   .evt_kind  (evt_kind),
   .sts_we    (sts_we),
   .cfg_all   (cfg_all),
   .flags_all (flags_all),
   .far_all   (far_all)
);

// File: tb/tb_ecc_event_monitor.sv
`timescale 1ns/1ps
module tb_ecc_event_monitor;
   localparam int NM = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_sel = 1'b0;
   logic         reg_wr = 1'b0;
   logic [7:0]   reg_addr = '0;
   logic [1:0]   reg_size = 2'b10;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  rdata_w;
   logic [31:0]  rdata_n;
   logic         irq_w;
   logic         irq_n;
   logic [2*NM-1:0]  evt_kind = '0;
   logic [32*NM-1:0] evt_addr = '0;
   logic [64*NM-1:0] evt_data = '0;
   logic [32*NM-1:0] evt_code = '0;
   logic [3:0]   kind_n = '0;
   logic [63:0]  addr_n = '0;
   logic [63:0]  data_n = '0;
   logic [63:0]  code_n = '0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ecc_event_monitor #(.NUM_MON(NM), .ADDR_W(8), .WIDE_DATA(1)) dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
      .reg_rdata(rdata_w), .evt_kind(evt_kind), .evt_addr(evt_addr),
      .evt_data(evt_data), .evt_code(evt_code), .irq(irq_w));

   ecc_event_monitor #(.NUM_MON(2), .ADDR_W(8), .WIDE_DATA(0)) dut_n (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
      .reg_rdata(rdata_n), .evt_kind(kind_n), .evt_addr(addr_n),
      .evt_data(data_n), .evt_code(code_n), .irq(irq_n));

   function automatic logic [7:0] a_reg(input int x, input int off);
      return 8'(32 * x + off);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'b10);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_size = sz;
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0; reg_size = 2'b10;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v,
                     input bit narrow = 1'b0, input logic [1:0] sz = 2'b10);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a; reg_size = sz;
      #1;
      v = narrow ? rdata_n : rdata_w;
      reg_sel = 1'b0; reg_size = 2'b10;
   endtask

   task automatic set_ev(input int x, input logic [1:0] k, input logic [31:0] a,
                         input logic [63:0] d, input logic [31:0] c);
      evt_kind[2*(x-1) +: 2]  = k;
      evt_addr[32*(x-1) +: 32] = a;
      evt_data[64*(x-1) +: 64] = d;
      evt_code[32*(x-1) +: 32] = c;
   endtask

   task automatic fire();
      @(negedge clk);
      evt_kind = '0;
   endtask

   task automatic ev(input int x, input logic [1:0] k, input logic [31:0] a,
                     input logic [63:0] d, input logic [31:0] c);
      @(negedge clk);
      set_ev(x, k, a, d, c);
      fire();
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h00, v); chk("R1 global", v, 0);
      rd(a_reg(1, 0), v); chk("R1 cfg1", v, 0);
      rd(a_reg(5, 4), v); chk("R1 sts5", v, 0);
      rd(a_reg(3, 8), v); chk("R1 far3", v, 0);
      chk("R1 irq", {31'b0, irq_w}, 0);
   endtask

   task automatic t_global();
      logic [31:0] v;
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, v); chk("R2 global bits", v, 32'h0000_000F);
      wr(8'h00, 32'h0000_0000);
      rd(8'h00, v); chk("R2 global cleared", v, 0);
   endtask

   task automatic t_config();
      logic [31:0] v;
      wr(a_reg(3, 0), 32'hFFFF_FFFF);
      rd(a_reg(3, 0), v); chk("R3 cfg3 bits", v, 32'h0000_003C);
      rd(a_reg(2, 0), v); chk("R3 cfg2 untouched", v, 0);
      wr(a_reg(3, 0), 32'h0);
   endtask

   task automatic t_flags();
      logic [31:0] v;
      ev(2, 2'd1, 0, 0, 0);
      rd(a_reg(2, 4), v); chk("R4 single flag", v, 32'h1);
      ev(2, 2'd2, 0, 0, 0);
      rd(a_reg(2, 4), v); chk("R4 double rd flag", v, 32'h3);
      ev(2, 2'd3, 0, 0, 0);
      rd(a_reg(2, 4), v); chk("R4 partial write flag", v, 32'h7);
      rd(a_reg(1, 4), v); chk("R4 other slot clear", v, 0);
      wr(a_reg(2, 4), 32'hFFFF_FFFF);
      rd(a_reg(2, 4), v); chk("R5 write ones no effect", v, 32'h7);
      wr(a_reg(2, 4), 32'h0000_0006);
      rd(a_reg(2, 4), v); chk("R5 clear bit0 only", v, 32'h6);
      wr(a_reg(2, 4), 32'h0);
      rd(a_reg(2, 4), v); chk("R5 clear all", v, 0);
   endtask

   task automatic t_race();
      logic [31:0] v;
      ev(1, 2'd1, 0, 0, 0);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a_reg(1, 4); reg_wdata = 0;
      set_ev(1, 2'd2, 0, 0, 0);
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0; evt_kind = '0;
      rd(a_reg(1, 4), v); chk("R5 set during clear other bit", v, 32'h2);
      @(negedge clk);
      reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a_reg(1, 4); reg_wdata = 0;
      set_ev(1, 2'd1, 0, 0, 0);
      @(negedge clk);
      reg_sel = 1'b0; reg_wr = 1'b0; evt_kind = '0;
      rd(a_reg(1, 4), v); chk("R5 set wins over clear", v, 32'h1);
      wr(a_reg(1, 4), 0);
   endtask

   task automatic t_latch();
      logic [31:0] v;
      wr(a_reg(4, 0), 32'h20);
      ev(4, 2'd1, 32'h1000_0040, 64'hAAAA_BBBB_CCCC_DDDD, 32'h55);
      rd(a_reg(4, 8),  v); chk("R6 far", v, 32'h1000_0040);
      rd(a_reg(4, 12), v); chk("R6 fdl", v, 32'hCCCC_DDDD);
      rd(a_reg(4, 16), v); chk("R6 fdh", v, 32'hAAAA_BBBB);
      rd(a_reg(4, 20), v); chk("R6 fec", v, 32'h55);
      ev(4, 2'd2, 32'h2000_0080, 64'h1111_2222_3333_4444, 32'h66);
      rd(a_reg(4, 8),  v); chk("R6 overwrite far", v, 32'h2000_0080);
      rd(a_reg(4, 16), v); chk("R6 overwrite fdh", v, 32'h1111_2222);
      ev(4, 2'd3, 32'h3000_0000, 64'h9, 32'h77);
      rd(a_reg(4, 8),  v); chk("R6 partial write no latch", v, 32'h2000_0080);
      rd(a_reg(4, 20), v); chk("R6 partial write code kept", v, 32'h66);
      wr(a_reg(4, 0), 32'h0);
      ev(4, 2'd1, 32'h4000_0000, 64'h5, 32'h88);
      rd(a_reg(4, 8),  v); chk("R6 latch disabled", v, 32'h2000_0080);
      ev(5, 2'd1, 32'h5000_0000, 64'h5, 32'h99);
      rd(a_reg(5, 8),  v); chk("R6 never enabled", v, 0);
      wr(a_reg(4, 4), 0);
      wr(a_reg(5, 4), 0);
   endtask

   task automatic t_irq();
      ev(3, 2'd1, 0, 0, 0);
      chk("R8 no enables", {31'b0, irq_w}, 0);
      wr(8'h00, 32'h1);
      chk("R8 master only", {31'b0, irq_w}, 0);
      wr(8'h00, 32'h3);
      chk("R8 master and global class", {31'b0, irq_w}, 1);
      wr(8'h00, 32'h5);
      chk("R8 wrong global class", {31'b0, irq_w}, 0);
      wr(a_reg(3, 0), 32'h4);
      chk("R8 slot enable", {31'b0, irq_w}, 1);
      wr(8'h00, 32'h0);
      chk("R8 master off", {31'b0, irq_w}, 0);
      wr(8'h00, 32'h1);
      wr(a_reg(3, 4), 0);
      chk("R8 flag cleared", {31'b0, irq_w}, 0);
      wr(a_reg(3, 0), 0);
      wr(8'h00, 0);
   endtask

   task automatic t_size();
      logic [31:0] v;
      wr(8'h00, 32'h5);
      wr(8'h00, 32'h0, 2'b00);
      wr(8'h00, 32'hF, 2'b01);
      rd(8'h00, v); chk("R9 sub-word writes ignored", v, 32'h5);
      rd(8'h00, v, 1'b0, 2'b00); chk("R9 byte read zero", v, 0);
      rd(8'h00, v, 1'b0, 2'b01); chk("R9 half read zero", v, 0);
      wr(8'h00, 32'h0);
   endtask

   task automatic t_multi();
      logic [31:0] v;
      wr(a_reg(1, 0), 32'h20);
      wr(a_reg(5, 0), 32'h20);
      @(negedge clk);
      set_ev(1, 2'd1, 32'hA1, 64'hB1, 32'hC1);
      set_ev(2, 2'd3, 32'hA2, 64'hB2, 32'hC2);
      set_ev(5, 2'd2, 32'hA5, 64'hB5, 32'hC5);
      fire();
      rd(a_reg(1, 4), v); chk("R10 slot1 flags", v, 32'h1);
      rd(a_reg(2, 4), v); chk("R10 slot2 flags", v, 32'h4);
      rd(a_reg(5, 4), v); chk("R10 slot5 flags", v, 32'h2);
      rd(a_reg(3, 4), v); chk("R10 slot3 quiet", v, 0);
      rd(a_reg(1, 8), v); chk("R10 slot1 far", v, 32'hA1);
      rd(a_reg(5, 8), v); chk("R10 slot5 far", v, 32'hA5);
      rd(a_reg(2, 8), v); chk("R10 slot2 far", v, 0);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      rd(a_reg(6, 0), v); chk("R11 slot above range", v, 0);
      rd(a_reg(1, 24), v); chk("R11 unused offset", v, 0);
      rd(8'h04, v); chk("R11 global block gap", v, 0);
   endtask

   task automatic t_narrow();
      logic [31:0] v;
      wr(a_reg(2, 0), 32'h20);
      @(negedge clk);
      kind_n[3:2] = 2'd1; addr_n[63:32] = 32'h0000_0ABC;
      data_n[63:32] = 32'hDEAD_BEEF; code_n[63:32] = 32'h3F;
      @(negedge clk);
      kind_n = '0;
      rd(a_reg(2, 12), v, 1'b1); chk("R7 narrow data low", v, 32'hDEAD_BEEF);
      rd(a_reg(2, 16), v, 1'b1); chk("R7 narrow data high zero", v, 0);
      rd(a_reg(2, 8),  v, 1'b1); chk("R7 narrow address", v, 32'h0000_0ABC);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_global();
      t_config();
      t_flags();
      t_race();
      t_latch();
      t_irq();
      t_size();
      t_multi();
      t_unmapped();
      t_narrow();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule